// File: doc/BRIEF.md
# Manchester Line Encoder with Frame Tail

This block turns the serial transmit stream of a 10 Mb/s MAC into Manchester-coded symbols on a differential output pair. It runs from a 20 MHz clock and generates the 10 MHz bit clock itself. That bit clock goes back to the MAC, which presents one enable bit and one data bit for each bit cell.

Each line half-cell lasts one 20 MHz period. In the first half of a cell the pair carries the inverse of the data bit. In the second half it carries the bit itself, so every data cell has a transition at its centre.

When the enable drops, the encoder closes the frame so that the last transition on the line is positive-going. If the final bit was 1, that transition is already the rising edge at the centre of the final cell. If the final bit was 0, the encoder adds one high half-cell, so the rising edge falls at the boundary of the final cell. After the frame, both wires rest at the same level.

Top module: `manchester_tx`

## Requirements
- R1: `bit_clk` is 0 during reset and inverts on every `clk_20m` edge afterwards, so it is high during the first half of each cell and low during the second half.
- R2: `tx_en` and `tx_data` are sampled only on the `clk_20m` edge where `bit_clk` rises, and that edge starts a cell. Changes to these inputs at any other time have no effect on the line.
- R3: In the first half of a data cell, `line_p` is the inverse of the sampled data bit and `line_n` equals the data bit.
- R4: In the second half of a data cell, `line_p` equals the data bit and `line_n` is its inverse, so every data cell has a mid-cell transition.
- R5: When no cell is being sent, `line_p` and `line_n` both equal the parameter `IDLE_LEVEL` (default 0).
- R6: If the last bit of a frame was 1, the first cell sampled with `tx_en` low is idle in both halves.
- R7: If the last bit of a frame was 0, the first cell sampled with `tx_en` low drives `line_p`=1, `line_n`=0 in its first half and is idle in its second half.
- R8: Outside idle, `line_p` and `line_n` are always complementary.
- R9: During reset the line is idle and `bit_clk` is 0. The first edge after reset release starts a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_20m | input | 1 | 20 MHz clock; each period is one half-cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC, sampled at each cell start |
| tx_data | input | 1 | NRZ data bit, sampled at each cell start |
| bit_clk | output | 1 | 10 MHz bit clock to the MAC; rises at each cell start |
| line_p | output | 1 | Positive wire of the Manchester pair |
| line_n | output | 1 | Negative wire of the Manchester pair |

## Verification
The bench builds the block with the default `IDLE_LEVEL` of 0. It drives every bit pattern of every frame length from 1 to 8 bits, each followed by one to three enable-low cells. This covers both tail shapes after every possible final bit, back-to-back frames separated by a single tail cell, and every pair of neighbouring bit values. In every data cell the inputs are flipped halfway through, so each cell also checks that mid-cell changes are ignored.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Line symbol for one half-cell
  typedef enum logic [1:0] {
    SYM_IDLE = 2'd0,
    SYM_LO   = 2'd1,
    SYM_HI   = 2'd2
  } mc_sym_t;

  // Level of a data half-cell: inverse of the bit first, the bit itself second
  function automatic mc_sym_t half_sym(input logic bit_v, input logic second_half);
    logic lvl;
    lvl = second_half ? bit_v : ~bit_v;
    return lvl ? SYM_HI : SYM_LO;
  endfunction

  // Map a symbol to {line_p, line_n}
  function automatic logic [1:0] pair_of(input mc_sym_t s, input logic idle_lvl);
    case (s)
      SYM_HI:  return 2'b10;
      SYM_LO:  return 2'b01;
      default: return {idle_lvl, idle_lvl};
    endcase
  endfunction

endpackage

// File: rtl/mc_bitclk.sv
module mc_bitclk (
  input  logic clk,
  input  logic rst_n,
  output logic bit_clk,
  output logic cell_start
);
  // Divide by two; the edge where bit_clk rises begins a cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_clk <= 1'b0;
    else        bit_clk <= ~bit_clk;
  end

  assign cell_start = ~bit_clk;
endmodule

// File: rtl/mc_cell_fsm.sv
module mc_cell_fsm
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cell_start,
  input  logic    tx_en,
  input  logic    tx_data,
  output mc_sym_t sym,
  output logic    first_half,
  output logic    tail_half
);
  logic busy_q;
  logic data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      data_q     <= 1'b0;
      sym        <= SYM_IDLE;
      first_half <= 1'b0;
      tail_half  <= 1'b0;
    end else if (cell_start) begin
      if (tx_en) begin
        busy_q     <= 1'b1;
        data_q     <= tx_data;
        sym        <= half_sym(tx_data, 1'b0);
        first_half <= 1'b1;
        tail_half  <= 1'b0;
      end else begin
        busy_q     <= 1'b0;
        first_half <= 1'b0;
        // Last bit 0 needs one high half-cell to end on a rising edge
        if (busy_q && !data_q) begin
          sym       <= SYM_HI;
          tail_half <= 1'b1;
        end else begin
          sym       <= SYM_IDLE;
          tail_half <= 1'b0;
        end
      end
    end else begin
      first_half <= 1'b0;
      tail_half  <= 1'b0;
      sym        <= busy_q ? half_sym(data_q, 1'b1) : SYM_IDLE;
    end
  end
endmodule

// File: rtl/mc_line_drv.sv
module mc_line_drv
  import mc_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  mc_sym_t sym,
  output logic    line_p,
  output logic    line_n
);
  logic [1:0] pair;

  always_comb pair = pair_of(sym, IDLE_LEVEL);

  assign line_p = pair[1];
  assign line_n = pair[0];
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mc_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk_20m,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  output logic bit_clk,
  output logic line_p,
  output logic line_n
);
  // Internal events brought out as named wires for the checks below
  logic    cell_start;
  logic    first_half;
  logic    tail_half;
  mc_sym_t sym;

  mc_bitclk i_bitclk (
    .clk        (clk_20m),
    .rst_n      (rst_n),
    .bit_clk    (bit_clk),
    .cell_start (cell_start)
  );

  mc_cell_fsm i_fsm (
    .clk        (clk_20m),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .tx_en      (tx_en),
    .tx_data    (tx_data),
    .sym        (sym),
    .first_half (first_half),
    .tail_half  (tail_half)
  );

  mc_line_drv #(.IDLE_LEVEL(IDLE_LEVEL)) i_drv (
    .sym    (sym),
    .line_p (line_p),
    .line_n (line_n)
  );

  // R1: the first half of a data cell coincides with bit_clk high
  p_first_half_high_r1: assert property (@(posedge clk_20m) disable iff (!rst_n)
    first_half |-> bit_clk);

  // R2: a data cell only begins on the edge where bit_clk rose
  p_start_on_rise_r2: assert property (@(posedge clk_20m) disable iff (!rst_n)
    first_half |-> $rose(bit_clk));

  // R4: every data cell flips both wires at its centre
  p_mid_transition_r4: assert property (@(posedge clk_20m) disable iff (!rst_n)
    first_half |=> (line_p != $past(line_p)) && (line_n != $past(line_n)));

  // R5: equal wires only ever sit at the idle level
  p_idle_balanced_r5: assert property (@(posedge clk_20m) disable iff (!rst_n)
    (line_p == line_n) |-> (line_p == IDLE_LEVEL));

  // R6: once the tail half-cell is over, the line is balanced
  p_tail_then_idle_r6: assert property (@(posedge clk_20m) disable iff (!rst_n)
    tail_half |=> (line_p == IDLE_LEVEL) && (line_n == IDLE_LEVEL));

  // R7: the tail rises out of a low half-cell
  p_tail_rising_r7: assert property (@(posedge clk_20m) disable iff (!rst_n)
    tail_half |-> line_p && !line_n && !$past(line_p));

  // R8: outside idle the pair is complementary
  p_pair_complement_r8: assert property (@(posedge clk_20m) disable iff (!rst_n)
    (sym != SYM_IDLE) |-> (line_p != line_n));
endmodule

// File: tb/test_manchester_tx.sv
`timescale 1ns/1ps
module test_manchester_tx;
  localparam bit IL = 1'b0;

  logic clk_20m = 1'b0;
  logic rst_n   = 1'b0;
  logic tx_en   = 1'b0;
  logic tx_data = 1'b0;
  logic bit_clk, line_p, line_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Bench-side memory of the previous cell
  bit prev_en = 1'b0;
  bit prev_d  = 1'b0;

  always #2 clk_20m = ~clk_20m;

  manchester_tx #(.IDLE_LEVEL(IL)) i_manchester_tx (
    .clk_20m (clk_20m),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_data (tx_data),
    .bit_clk (bit_clk),
    .line_p  (line_p),
    .line_n  (line_n)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {bit_clk,p,n} got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Called at a falling edge while bit_clk is low; the next rising edge starts the cell
  task automatic send_cell(input bit en, input bit d);
    logic [1:0] h1, h2;
    if (en) begin
      h1 = {~d, d};                 // R3
      h2 = {d, ~d};                 // R4
    end else if (prev_en && !prev_d) begin
      h1 = 2'b10;                   // R7
      h2 = {IL, IL};
    end else begin
      h1 = {IL, IL};                // R5 / R6
      h2 = {IL, IL};
    end
    tx_en   = en;
    tx_data = d;
    @(negedge clk_20m);
    check(en ? "R3 first half" : (prev_en && !prev_d) ? "R7 tail" : "R6 idle",
          {bit_clk, line_p, line_n}, {1'b1, h1});
    // R2: flip the inputs mid-cell; they must not be seen
    tx_en   = ~en;
    tx_data = ~d;
    @(negedge clk_20m);
    check(en ? "R4 second half / R2" : "R5 idle half / R1",
          {bit_clk, line_p, line_n}, {1'b0, h2});
    tx_en   = 1'b0;
    tx_data = 1'b0;
    prev_en = en;
    prev_d  = d;
  endtask

  initial begin
    repeat (3) @(negedge clk_20m);
    // R9: reset state
    check("R9 reset", {bit_clk, line_p, line_n}, {1'b0, IL, IL});
    rst_n = 1'b1;
    // bit_clk is still low at this falling edge, so the next edge starts a cell
    send_cell(1'b0, 1'b0);
    for (int len = 1; len <= 8; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        for (int b = 0; b < len; b++) send_cell(1'b1, pat[b]);
        for (int g = 0; g <= pat % 3; g++) send_cell(1'b0, 1'b0);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete (got timeout, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule